// File: doc/BRIEF.md
# Toggle Bit Status Poller

This block runs on the host side of a flash interface. It decides whether a program or erase operation already sent to the device has finished. It is used after the operation command has been issued. A one-cycle `start_i` pulse tells the poller to begin. The poller then reads the device status byte through a request/acknowledge read port. It reads the byte in pairs and compares bit 6 between the two reads of each pair. If that bit stopped changing, the operation is over.

If the bit is still changing, the poller looks at bit 5 of the second read. Bit 5 is the device's time-exceeded flag. When the flag is clear, the poller reads another pair. When the flag is set, the poller does one more confirmation pair, because the toggling may have stopped at the same moment the flag rose. If that confirmation pair still shows a change, the operation has failed. The poller then writes a reset command byte to the device and reports failure. A limit on the number of polling pairs, set by a parameter, guards against a device that never settles.

States:
- `ST_IDLE`: wait for start.
- `ST_ISSUE`: launch a pair of reads and count it.
- `ST_WAIT_PAIR`: wait for the pair result.
- `ST_ISSUE_RECHK`: launch the confirmation pair.
- `ST_WAIT_RECHK`: wait for the confirmation result.
- `ST_WRITE_RST`: hold the reset command write until it is acknowledged.
- `ST_REPORT_OK`: one-cycle success report.
- `ST_REPORT_FAIL`: one-cycle failure report.

Transitions:
- IDLE→ISSUE on start.
- ISSUE→WAIT_PAIR always.
- WAIT_PAIR→REPORT_OK when the pair is unchanged.
- WAIT_PAIR→ISSUE_RECHK when the pair changed and the flag is set.
- WAIT_PAIR→WRITE_RST when the pair changed, the flag is clear and the budget is spent.
- WAIT_PAIR→ISSUE when the pair changed, the flag is clear and budget remains.
- ISSUE_RECHK→WAIT_RECHK always.
- WAIT_RECHK→WRITE_RST when the confirmation pair changed.
- WAIT_RECHK→REPORT_OK when the confirmation pair is unchanged.
- WRITE_RST→REPORT_FAIL on write acknowledge.
- REPORT_OK→IDLE and REPORT_FAIL→IDLE always.

Top module: `tbp_poller`

## Requirements
- R1: After reset, `rd_req_o`, `wr_req_o`, `done_o`, `ok_o` and `fail_o` are all low.
- R2: A `start_i` pulse while idle begins a pair of status reads. Each read completes on a clock edge where `rd_req_o` and `rd_ack_i` are both high, and `rd_data_i` is sampled on that edge. `rd_req_o` stays high until acknowledged.
- R3: Only bit 6 of the status byte is compared between the two reads of a pair. If it is equal, the poller reports success and performs no further reads.
- R4: If bit 6 differs and bit 5 of the second read is 0, and fewer than MAX_POLLS pairs have been read, another pair is read.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one confirmation pair is read. If bit 6 is equal within that pair, the poller reports success.
- R6: If bit 6 still differs within the confirmation pair, the poller writes the reset command and then reports failure.
- R7: The reset command write holds `wr_req_o` high with `wr_data_o` equal to RESET_CMD (default 8'hF0) until `wr_ack_i`. Exactly one write is made per failure and none per success. A read and a write are never requested together.
- R8: When the MAX_POLLS-th ordinary pair differs with bit 5 equal to 0, the poller writes the reset command and reports failure. Confirmation pairs do not count toward MAX_POLLS.
- R9: Each run ends with `done_o` high for exactly one cycle, with exactly one of `ok_o` or `fail_o` high in that cycle. `ok_o` and `fail_o` are low whenever `done_o` is low.
- R10: A `start_i` pulse while a run is in progress has no effect: no extra reads and no extra `done_o` pulse. No read is requested after `done_o` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Status byte returned by the device |
| wr_req_o | output | 1 | Command write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DATA_W | Command byte (RESET_CMD during a write) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Operation finished successfully (with done_o) |
| fail_o | output | 1 | Operation failed, reset issued (with done_o) |

## Verification
A corrupted state register or pair result shows up at the ports within one read pair. It appears as a wrong number of read handshakes, a missing or extra reset write, or `ok_o`/`fail_o` with the wrong polarity on the `done_o` cycle. A miscounted polling budget changes the read count by at least two reads, and it does so on the pair where the limit should have applied. The bench sweeps the device's toggle duration, the read index at which the time flag rises and the handshake latency. For each case it predicts the read count, the write count and the final verdict by arithmetic.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_PAIR,
        ST_ISSUE_RECHK,
        ST_WAIT_RECHK,
        ST_WRITE_RST,
        ST_REPORT_OK,
        ST_REPORT_FAIL
    } poll_state_t;

    typedef enum logic [1:0] {
        PR_IDLE,
        PR_FIRST,
        PR_SECOND,
        PR_PRESENT
    } pair_state_t;

    typedef struct packed {
        logic changed;
        logic time_over;
    } pair_result_t;

endpackage

// File: rtl/tbp_read_pair.sv
module tbp_read_pair
    import tbp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              pair_done_o,
    output pair_result_t      result_o
);

    pair_state_t  state_q;
    pair_state_t  state_d;
    logic         first_bit_q;
    pair_result_t result_q;

    // Bits other than the toggle and flag positions carry no meaning here.
    logic unused_status;
    assign unused_status = ^rd_data_i;

    // Next-state logic for the two-read sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_IDLE:    if (launch_i) state_d = PR_FIRST;
            PR_FIRST:   if (rd_ack_i) state_d = PR_SECOND;
            PR_SECOND:  if (rd_ack_i) state_d = PR_PRESENT;
            PR_PRESENT: state_d = PR_IDLE;
            default:    state_d = PR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PR_IDLE;
            first_bit_q <= 1'b0;
            result_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PR_FIRST && rd_ack_i) begin
                first_bit_q <= rd_data_i[TOGGLE_BIT];
            end
            if (state_q == PR_SECOND && rd_ack_i) begin
                result_q.changed   <= first_bit_q ^ rd_data_i[TOGGLE_BIT];
                result_q.time_over <= rd_data_i[TIMEOUT_BIT];
            end
        end
    end

    assign rd_req_o    = (state_q == PR_FIRST) || (state_q == PR_SECOND);
    assign pair_done_o = (state_q == PR_PRESENT);
    assign result_o    = result_q;

endmodule

// File: rtl/tbp_poll_budget.sv
module tbp_poll_budget #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bump_i,
    output logic exhausted_o
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

    logic [CNT_W-1:0] count_q;

    // Saturating count of ordinary polling pairs launched in this run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (bump_i && (count_q < LIMIT)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign exhausted_o = (count_q >= LIMIT);

endmodule

// File: rtl/tbp_poll_fsm.sv
module tbp_poll_fsm
    import tbp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         pair_done_i,
    input  pair_result_t result_i,
    input  logic         exhausted_i,
    input  logic         wr_ack_i,
    output logic         launch_o,
    output logic         clear_o,
    output logic         bump_o,
    output logic         wr_req_o,
    output logic         done_o,
    output logic         ok_o,
    output logic         fail_o
);

    poll_state_t state_q;
    poll_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_d = ST_WAIT_PAIR;
            end
            ST_WAIT_PAIR: begin
                if (pair_done_i) begin
                    if (!result_i.changed) begin
                        state_d = ST_REPORT_OK;
                    end else if (result_i.time_over) begin
                        state_d = ST_ISSUE_RECHK;
                    end else if (exhausted_i) begin
                        state_d = ST_WRITE_RST;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE_RECHK: begin
                state_d = ST_WAIT_RECHK;
            end
            ST_WAIT_RECHK: begin
                if (pair_done_i) begin
                    state_d = result_i.changed ? ST_WRITE_RST : ST_REPORT_OK;
                end
            end
            ST_WRITE_RST: begin
                if (wr_ack_i) state_d = ST_REPORT_FAIL;
            end
            ST_REPORT_OK:   state_d = ST_IDLE;
            ST_REPORT_FAIL: state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        launch_o = 1'b0;
        bump_o   = 1'b0;
        wr_req_o = 1'b0;
        done_o   = 1'b0;
        ok_o     = 1'b0;
        fail_o   = 1'b0;
        clear_o  = (state_q == ST_IDLE) && start_i;
        unique case (state_q)
            ST_ISSUE: begin
                launch_o = 1'b1;
                bump_o   = 1'b1;
            end
            ST_ISSUE_RECHK: launch_o = 1'b1;
            ST_WRITE_RST:   wr_req_o = 1'b1;
            ST_REPORT_OK: begin
                done_o = 1'b1;
                ok_o   = 1'b1;
            end
            ST_REPORT_FAIL: begin
                done_o = 1'b1;
                fail_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
    import tbp_pkg::*;
#(
    parameter int              DATA_W      = 8,
    parameter int              TOGGLE_BIT  = 6,
    parameter int              TIMEOUT_BIT = 5,
    parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0,
    parameter int              MAX_POLLS   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_req_o,
    input  logic              wr_ack_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              ok_o,
    output logic              fail_o
);

    logic         launch;
    logic         clear;
    logic         bump;
    logic         pair_done;
    logic         exhausted;
    pair_result_t result;

    tbp_read_pair #(
        .DATA_W      (DATA_W),
        .TOGGLE_BIT  (TOGGLE_BIT),
        .TIMEOUT_BIT (TIMEOUT_BIT)
    ) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .rd_req_o    (rd_req_o),
        .rd_ack_i    (rd_ack_i),
        .rd_data_i   (rd_data_i),
        .pair_done_o (pair_done),
        .result_o    (result)
    );

    tbp_poll_budget #(
        .MAX_POLLS   (MAX_POLLS)
    ) u_budget (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .bump_i      (bump),
        .exhausted_o (exhausted)
    );

    tbp_poll_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pair_done_i (pair_done),
        .result_i    (result),
        .exhausted_i (exhausted),
        .wr_ack_i    (wr_ack_i),
        .launch_o    (launch),
        .clear_o     (clear),
        .bump_o      (bump),
        .wr_req_o    (wr_req_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .fail_o      (fail_o)
    );

    assign wr_data_o = wr_req_o ? RESET_CMD : '0;

endmodule

// File: rtl/tbp_poller_chk.sv
module tbp_poller_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req_o,
    input logic rd_ack_i,
    input logic wr_req_o,
    input logic wr_ack_i,
    input logic done_o,
    input logic ok_o,
    input logic fail_o
);

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);                  // R2

    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> wr_req_o);                  // R7

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));                               // R7

    AST_FAIL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i) |=> (done_o && fail_o));         // R6

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o != fail_o));                           // R9

    AST_VERDICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!ok_o && !fail_o));                        // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                    // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!rd_req_o && !wr_req_o));                   // R10

endmodule

bind tbp_poller tbp_poller_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req_o (rd_req_o),
    .rd_ack_i (rd_ack_i),
    .wr_req_o (wr_req_o),
    .wr_ack_i (wr_ack_i),
    .done_o   (done_o),
    .ok_o     (ok_o),
    .fail_o   (fail_o)
);

// File: tb/tb_tbp_poller.sv
module tb_tbp_poller;

    localparam int MAXP = 3;
    localparam int NEVER = 99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rd_req_o;
    logic       rd_ack_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       wr_req_o;
    logic       wr_ack_i = 1'b0;
    logic [7:0] wr_data_o;
    logic       done_o;
    logic       ok_o;
    logic       fail_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Scenario knobs (written by the main initial only).
    int tog_len = 0;
    int flag_at = NEVER;
    int lat = 0;
    int rd_base = 0;

    // Cumulative observations (each written by one block only).
    int rd_total = 0;
    int wr_total = 0;
    int wr_bad_data = 0;
    int done_total = 0;
    int ok_total = 0;
    int fail_total = 0;
    int verdict_bad = 0;
    int overlap_total = 0;
    int rd_wait = 0;
    int wr_wait = 0;

    always #2 clk = ~clk;

    tbp_poller #(.MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i), .wr_data_o(wr_data_o),
        .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o)
    );

    function automatic logic [7:0] status_byte(input int i);
        int   t;
        logic [7:0] b;
        t = (i < tog_len) ? i : tog_len;
        b = 8'((i * 53 + tog_len * 11) & 8'h9F);
        b[6] = t[0];
        b[5] = (i >= flag_at);
        return b;
    endfunction

    // Device model: answers reads and writes away from the active edge.
    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i <= 1'b0;
        end else if (rd_req_o) begin
            if (rd_wait >= lat) begin
                rd_ack_i  <= 1'b1;
                rd_data_i <= status_byte(rd_total - rd_base);
                rd_total  <= rd_total + 1;
                rd_wait   <= 0;
            end else begin
                rd_wait <= rd_wait + 1;
            end
        end
        if (wr_ack_i) begin
            wr_ack_i <= 1'b0;
        end else if (wr_req_o) begin
            if (wr_wait >= lat) begin
                wr_ack_i <= 1'b1;
                wr_total <= wr_total + 1;
                if (wr_data_o != 8'hF0) wr_bad_data <= wr_bad_data + 1;
                wr_wait  <= 0;
            end else begin
                wr_wait <= wr_wait + 1;
            end
        end
    end

    // Output monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                done_total <= done_total + 1;
                if (ok_o && !fail_o) ok_total <= ok_total + 1;
                else if (fail_o && !ok_o) fail_total <= fail_total + 1;
                else verdict_bad <= verdict_bad + 1;
            end else if (ok_o || fail_o) begin
                verdict_bad <= verdict_bad + 1;
            end
            if (rd_req_o && wr_req_o) overlap_total <= overlap_total + 1;
        end
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (T=%0d F=%0d L=%0d)",
                     tag, act, exp, tog_len, flag_at, lat);
        end
    endtask

    // Arithmetic reference: path 0 direct ok, 1 recheck ok, 2 recheck fail, 3 limit fail.
    task automatic predict(output int reads, output int path, output int pairs);
        int n;
        int polls;
        n = 0;
        polls = 0;
        path = -1;
        while (path < 0) begin
            polls++;
            n += 2;
            if (!((n - 2) < tog_len)) begin
                path = 0;
            end else if ((n - 1) >= flag_at) begin
                n += 2;
                path = ((n - 2) < tog_len) ? 2 : 1;
            end else if (polls == MAXP) begin
                path = 3;
            end
        end
        reads = n;
        pairs = polls;
    endtask

    task automatic run_case(input int t, input int f, input int l);
        int exp_reads, path, pairs;
        int rd0, wr0, dn0, ok0, fl0, vb0, ov0, bad0;
        int k;
        string vtag;
        tog_len = t;
        flag_at = f;
        lat = l;
        @(negedge clk);
        rd_base = rd_total;
        rd0 = rd_total; wr0 = wr_total; dn0 = done_total;
        ok0 = ok_total; fl0 = fail_total; vb0 = verdict_bad;
        ov0 = overlap_total; bad0 = wr_bad_data;
        predict(exp_reads, path, pairs);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;   // R10: ignored, run is in progress
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        while (done_total == dn0 && k < 400) begin
            @(negedge clk);
            k++;
        end
        repeat (10) @(negedge clk);
        check(rd_total - rd0 == exp_reads, (pairs > 1) ? "R4" : "R2",
              rd_total - rd0, exp_reads);
        check(done_total - dn0 == 1, "R10", done_total - dn0, 1);
        check(verdict_bad == vb0, "R9", verdict_bad - vb0, 0);
        case (path)
            0: vtag = "R3";
            1: vtag = "R5";
            2: vtag = "R6";
            default: vtag = "R8";
        endcase
        if (path <= 1) begin
            check(ok_total - ok0 == 1 && fail_total == fl0, vtag, ok_total - ok0, 1);
            check(wr_total == wr0, "R7", wr_total - wr0, 0);
        end else begin
            check(fail_total - fl0 == 1 && ok_total == ok0, vtag, fail_total - fl0, 1);
            check(wr_total - wr0 == 1, "R7", wr_total - wr0, 1);
        end
        check(wr_bad_data == bad0 && overlap_total == ov0, "R7",
              (wr_bad_data - bad0) + (overlap_total - ov0), 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: quiet outputs during and after reset
        check(!rd_req_o && !wr_req_o && !done_o && !ok_o && !fail_o, "R1",
              {rd_req_o, wr_req_o, done_o, ok_o, fail_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!rd_req_o && !wr_req_o && !done_o && !ok_o && !fail_o, "R1",
              {rd_req_o, wr_req_o, done_o, ok_o, fail_o}, 0);
        for (int l = 0; l < 2; l++) begin
            for (int t = 0; t <= 10; t++) begin
                for (int fi = 0; fi <= 11; fi++) begin
                    run_case(t, (fi == 11) ? NEVER : fi, l);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule